// File: doc/BRIEF.md
# Power Controller Request Sequencer

A register-mapped sequencer that accepts operating-level changes for two processor clusters, a big one and a little one. It also accepts read commands aimed at a built-in table of operating points. Only one request runs at a time. A level change stays busy for `LVL_DELAY` cycles, which models the regulator and clock settling. A table read stays busy for `CFG_DELAY` cycles. Both delays must be at least 1.

Every request ends by setting either its complete bit or its error bit in one shared status word. The interrupt line stays high for as long as any status bit is set. Reading the status word returns its contents and clears it.

Bus access is a single cycle. A write is taken on the clock edge where `wr_en_i` is high. A read is taken on the edge where `rd_en_i` is high, and `rdata_o` holds the value from that edge onward. Addresses are byte offsets on word boundaries:

| Offset | Register |
|---|---|
| 0x00 | big-cluster level |
| 0x04 | big-cluster busy |
| 0x08 | little-cluster level |
| 0x0C | little-cluster busy |
| 0x10 | command |
| 0x14 | command busy |
| 0x18 | status |
| 0x1C | interrupt flag |
| 0x70 | write scratch |
| 0x74 | read data |

Top module: `pwr_req_seq`

## Requirements
- R1: After reset, both level registers read 0, the status register reads 0, read data (0x74) reads 0, and `irq_o` is low.
- R2: Writing an index below 8 to a level register (0x00 big, 0x08 little) starts a change. The complete bit (bit 0 for big, bit 4 for little) rises exactly `LVL_DELAY` cycles after the write edge. At that same edge the level register takes the new index. Until then it keeps the old index.
- R3: Writing an index of 8 or more to a level register sets that cluster's error bit (bit 1 big, bit 5 little) at the write edge. The level stays unchanged and no complete bit follows.
- R4: A command word with bit 31 set, function code 6 in bits 23:20, and a table word offset in bits 11:0 starts a table read. Exactly `CFG_DELAY` cycles later, status bit 8 rises, and at that same edge the read-data register already holds the entry.
- R5: Table entry i (0..7) of the big cluster sits at word offset 0x304+i, and of the little cluster at 0x30C+i. Each entry holds the voltage 900+25*i in bits 31:20. Bits 19:0 hold the frequency in 20 kHz units: 25000+2500*i for big, 17500+2500*i for little.
- R6: A command with bit 31 set but a function code other than 6, or a word offset outside both tables, sets status bit 9 at the write edge and leaves read data unchanged.
- R7: A command word with bit 31 clear starts nothing and sets no status bit.
- R8: While a request is busy, a new level write or start command is ignored. It sets its own type's error bit at the write edge, and the running request completes normally.
- R9: A status read returns the value held before the read edge and clears every bit. A bit set on that same edge survives.
- R10: `irq_o` is high exactly while the status register is nonzero. It drops in the cycle after a clearing read if nothing new was set.
- R11: The busy registers (0x04 big, 0x0C little, 0x14 command) read 1 in bit 0 while a request of that type is running, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered on the read edge |
| irq_o | output | 1 | Level interrupt, high while status is nonzero |

## Verification
A broken busy counter shows as `irq_o` rising one or more cycles away from the exact `LVL_DELAY` or `CFG_DELAY` edge. The bench watches every cycle of that window. A corrupted level, pending index or table entry shows at the first read of the level or read-data register after completion. A wrong busy or clear decision shows at the very next status read, as a missing or extra complete or error bit. The same-edge set-and-clear case is driven deliberately, because a clear-wins bug is visible only there.

// File: rtl/pwr_req_pkg.sv
package pwr_req_pkg;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 8;
  localparam int NUM_TYPES = 3;
  localparam int STAT_W    = 4 * NUM_TYPES;
  localparam int NUM_CL    = 2;

  typedef enum logic [1:0] {
    REQ_BIG = 2'd0,
    REQ_LIT = 2'd1,
    REQ_CFG = 2'd2
  } req_e;

  localparam logic [ADDR_W-1:0] OFF_BIG_LVL = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_BIG_REQ = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_LIT_LVL = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_LIT_REQ = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_CMD     = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_CMD_REQ = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_STAT    = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_FLAG    = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_WDAT    = 8'h70;
  localparam logic [ADDR_W-1:0] OFF_RDAT    = 8'h74;

  localparam int          CMD_GO = 31;
  localparam int          FN_LSB = 20;
  localparam int          FN_W   = 4;
  localparam logic [3:0]  FN_OPP = 4'd6;
  localparam int          WOFF_W = 12;

  localparam logic [15:0] BIG_TBL_BYTE = 16'h0C10;
  localparam logic [15:0] LIT_TBL_BYTE = 16'h0C30;
endpackage

// File: rtl/pwr_opp_table.sv
module pwr_opp_table
  import pwr_req_pkg::*;
#(
  parameter int NUM_OPPS = 8,
  parameter logic [WOFF_W-1:0] BIG_WBASE = 12'h304,
  parameter logic [WOFF_W-1:0] LIT_WBASE = 12'h30C,
  parameter int BIG_F0 = 25000,
  parameter int LIT_F0 = 17500,
  parameter int F_STEP = 2500,
  parameter int V0     = 900,
  parameter int V_STEP = 25
) (
  input  logic [WOFF_W-1:0] woff_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] entry_o
);
  logic [NUM_CL-1:0] cl_hit;
  logic [DATA_W-1:0] cl_entry [NUM_CL];

  for (genvar c = 0; c < NUM_CL; c++) begin : g_cl
    localparam logic [WOFF_W-1:0] WBASE = (c == 0) ? BIG_WBASE : LIT_WBASE;
    localparam int F0 = (c == 0) ? BIG_F0 : LIT_F0;
    logic [WOFF_W-1:0] rel;
    assign rel       = woff_i - WBASE;
    assign cl_hit[c] = (woff_i >= WBASE) && (rel < WOFF_W'(NUM_OPPS));
    // voltage in the top 12 bits, frequency (20 kHz units) in the low 20
    assign cl_entry[c] = {12'(V0 + V_STEP * int'(rel)), 20'(F0 + F_STEP * int'(rel))};
  end

  assign hit_o   = |cl_hit;
  assign entry_o = cl_hit[1] ? cl_entry[1] : cl_entry[0];
endmodule

// File: rtl/pwr_req_engine.sv
module pwr_req_engine
  import pwr_req_pkg::*;
#(
  parameter int LVL_DELAY = 40,
  parameter int CFG_DELAY = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  req_e type_i,
  output logic busy_o,
  output req_e type_o,
  output logic done_o
);
  localparam int MAX_D = (LVL_DELAY > CFG_DELAY) ? LVL_DELAY : CFG_DELAY;
  localparam int CNT_W = $clog2(MAX_D + 1);

  logic             busy_q;
  req_e             type_q;
  logic [CNT_W-1:0] cnt_q;

  assign busy_o = busy_q;
  assign type_o = type_q;
  assign done_o = busy_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      type_q <= REQ_BIG;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      type_q <= type_i;
      cnt_q  <= (type_i == REQ_CFG) ? CNT_W'(CFG_DELAY - 1) : CNT_W'(LVL_DELAY - 1);
    end else if (done_o) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assert_no_start_when_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
  assert_busy_until_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !done_o) |=> busy_q);
  assert_type_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !done_o) |=> $stable(type_q));
endmodule

// File: rtl/pwr_status_reg.sv
module pwr_status_reg
  import pwr_req_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] set_i,
  input  logic              clr_i,
  output logic [STAT_W-1:0] status_o,
  output logic              irq_o
);
  logic [STAT_W-1:0] status_q;

  // new events win over a clearing read on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (clr_i ? '0 : status_q) | set_i;
  end

  assign status_o = status_q;
  assign irq_o    = |status_q;

  assert_bits_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((status_q & $past(status_q)) == $past(status_q)));
  assert_set_survives_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((status_q & $past(set_i)) == $past(set_i)));
  assert_irq_drops_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && set_i == '0) |=> !irq_o);
endmodule

// File: rtl/pwr_req_seq.sv
module pwr_req_seq
  import pwr_req_pkg::*;
#(
  parameter int NUM_OPPS  = 8,
  parameter int LVL_DELAY = 40,
  parameter int CFG_DELAY = 12,
  parameter int BIG_F0    = 25000,
  parameter int LIT_F0    = 17500,
  parameter int F_STEP    = 2500,
  parameter int V0        = 900,
  parameter int V_STEP    = 25
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int IDX_W = $clog2(NUM_OPPS);
  localparam logic [WOFF_W-1:0] BIG_WBASE = WOFF_W'(BIG_TBL_BYTE >> 2);
  localparam logic [WOFF_W-1:0] LIT_WBASE = WOFF_W'(LIT_TBL_BYTE >> 2);

  // ---- decode ----
  logic [NUM_CL-1:0] lvl_wr, lvl_ok;
  logic cmd_wr, cmd_go, cmd_ok, tbl_hit;
  logic [DATA_W-1:0] tbl_entry;

  assign lvl_wr[0] = wr_en_i && (addr_i == OFF_BIG_LVL);
  assign lvl_wr[1] = wr_en_i && (addr_i == OFF_LIT_LVL);
  for (genvar c = 0; c < NUM_CL; c++) begin : g_lvl_ok
    assign lvl_ok[c] = (wdata_i < DATA_W'(NUM_OPPS));
  end

  assign cmd_wr = wr_en_i && (addr_i == OFF_CMD);
  assign cmd_go = cmd_wr && wdata_i[CMD_GO];
  assign cmd_ok = (wdata_i[FN_LSB +: FN_W] == FN_OPP) && tbl_hit;

  pwr_opp_table #(
    .NUM_OPPS (NUM_OPPS),
    .BIG_WBASE(BIG_WBASE),
    .LIT_WBASE(LIT_WBASE),
    .BIG_F0   (BIG_F0),
    .LIT_F0   (LIT_F0),
    .F_STEP   (F_STEP),
    .V0       (V0),
    .V_STEP   (V_STEP)
  ) u_tbl (
    .woff_i (wdata_i[WOFF_W-1:0]),
    .hit_o  (tbl_hit),
    .entry_o(tbl_entry)
  );

  req_e req_type;
  logic req_any, req_ok;
  always_comb begin
    req_any  = 1'b1;
    req_type = REQ_BIG;
    req_ok   = lvl_ok[0];
    if (lvl_wr[0]) begin
      req_type = REQ_BIG;
      req_ok   = lvl_ok[0];
    end else if (lvl_wr[1]) begin
      req_type = REQ_LIT;
      req_ok   = lvl_ok[1];
    end else if (cmd_go) begin
      req_type = REQ_CFG;
      req_ok   = cmd_ok;
    end else begin
      req_any = 1'b0;
      req_ok  = 1'b0;
    end
  end

  // ---- engine ----
  logic eng_busy, eng_done, accept, reject;
  req_e eng_type;

  assign accept = req_any && req_ok && !eng_busy;
  assign reject = req_any && !(req_ok && !eng_busy);

  pwr_req_engine #(
    .LVL_DELAY(LVL_DELAY),
    .CFG_DELAY(CFG_DELAY)
  ) u_eng (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(accept),
    .type_i (req_type),
    .busy_o (eng_busy),
    .type_o (eng_type),
    .done_o (eng_done)
  );

  // ---- status ----
  logic [STAT_W-1:0] stat_set, stat;
  logic              stat_clr;

  always_comb begin
    stat_set = '0;
    if (reject)   stat_set[4*int'(req_type) + 1] = 1'b1;
    if (eng_done) stat_set[4*int'(eng_type)]     = 1'b1;
  end
  assign stat_clr = rd_en_i && (addr_i == OFF_STAT);

  pwr_status_reg u_stat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (stat_set),
    .clr_i   (stat_clr),
    .status_o(stat),
    .irq_o   (irq_o)
  );

  // ---- state ----
  logic [IDX_W-1:0]  level_q [NUM_CL];
  logic [IDX_W-1:0]  pend_lvl_q;
  logic [DATA_W-1:0] pend_entry_q, cmd_q, wdat_q, rdat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < NUM_CL; c++) level_q[c] <= '0;
      pend_lvl_q   <= '0;
      pend_entry_q <= '0;
      cmd_q        <= '0;
      wdat_q       <= '0;
      rdat_q       <= '0;
    end else begin
      if (accept) begin
        pend_lvl_q   <= wdata_i[IDX_W-1:0];
        pend_entry_q <= tbl_entry;
      end
      if (eng_done) begin
        case (eng_type)
          REQ_BIG: level_q[0] <= pend_lvl_q;
          REQ_LIT: level_q[1] <= pend_lvl_q;
          default: rdat_q     <= pend_entry_q;
        endcase
      end
      if (cmd_wr) cmd_q <= wdata_i;
      if (wr_en_i && addr_i == OFF_WDAT) wdat_q <= wdata_i;
    end
  end

  // ---- read port ----
  logic [DATA_W-1:0] rd_val;
  always_comb begin
    rd_val = '0;
    case (addr_i)
      OFF_BIG_LVL: rd_val = DATA_W'(level_q[0]);
      OFF_LIT_LVL: rd_val = DATA_W'(level_q[1]);
      OFF_BIG_REQ: rd_val = DATA_W'(eng_busy && eng_type == REQ_BIG);
      OFF_LIT_REQ: rd_val = DATA_W'(eng_busy && eng_type == REQ_LIT);
      OFF_CMD_REQ: rd_val = DATA_W'(eng_busy && eng_type == REQ_CFG);
      OFF_CMD:     rd_val = cmd_q;
      OFF_STAT:    rd_val = DATA_W'(stat);
      OFF_FLAG:    rd_val = DATA_W'(irq_o);
      OFF_WDAT:    rd_val = wdat_q;
      OFF_RDAT:    rd_val = rdat_q;
      default:     rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_val;
  end

  assert_big_level_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(eng_done && eng_type == REQ_BIG) |=> $stable(level_q[0]));
  assert_lit_level_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(eng_done && eng_type == REQ_LIT) |=> $stable(level_q[1]));
  assert_bad_cmd_err_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_go && !cmd_ok) |=> stat[9]);
  assert_busy_cmd_err_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_go && eng_busy) |=> stat[9]);
  assert_rdata_at_cpl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat[8]) |-> (rdat_q == $past(pend_entry_q)));
  assert_no_start_bit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && !wdata_i[CMD_GO] && !eng_busy) |=> !eng_busy);
endmodule

// File: tb/pwr_req_seq_tb.sv
module pwr_req_seq_tb;
  localparam int LVL_D = 6;
  localparam int CFG_D = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pwr_req_seq #(.LVL_DELAY(LVL_D), .CFG_DELAY(CFG_D)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  localparam logic [31:0] GO  = 32'h8000_0000;
  localparam logic [31:0] FN6 = 32'h0060_0000;

  function automatic logic [31:0] exp_entry(input int cl, input int i);
    int f0 = (cl == 0) ? 25000 : 17500;
    return {12'(900 + 25 * i), 20'(f0 + 2500 * i)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  // irq must stay low for d-1 cycles after the write edge and be high at cycle d
  task automatic check_window(input string req, input int d);
    logic early = 1'b0;
    for (int k = 1; k < d; k++) begin
      @(negedge clk);
      if (irq) early = 1'b1;
    end
    check({req, " no early complete"}, 32'(early), 32'd0);
    @(negedge clk);
    check({req, " complete on time"}, 32'(irq), 32'd1);
  endtask

  task automatic wait_irq();
    for (int k = 0; k < 50 && !irq; k++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", 32'(irq), 32'd0);
    rd(8'h00, d); check("R1 big level", d, 32'd0);
    rd(8'h08, d); check("R1 little level", d, 32'd0);
    rd(8'h74, d); check("R1 read data", d, 32'd0);
    rd(8'h18, d); check("R1 status", d, 32'd0);
  endtask

  task automatic t_big_level();
    logic [31:0] d;
    wr(8'h00, 32'd5);
    check_window("R2 big", LVL_D);
    rd(8'h00, d); check("R2 big level", d, 32'd5);
    rd(8'h18, d); check("R2 big complete bit0", d, 32'h001);
    rd(8'h18, d); check("R9 status cleared", d, 32'h0);
    check("R10 irq low after clear", 32'(irq), 32'd0);
  endtask

  task automatic t_little_level();
    logic [31:0] d;
    wr(8'h08, 32'd3);
    rd(8'h0C, d); check("R11 little busy", d, 32'd1);
    rd(8'h08, d); check("R2 little old level held", d, 32'd0);
    rd(8'h04, d); check("R11 big not busy", d, 32'd0);
    wait_irq();
    rd(8'h08, d); check("R2 little level", d, 32'd3);
    rd(8'h18, d); check("R2 little complete bit4", d, 32'h010);
    rd(8'h0C, d); check("R11 little idle", d, 32'd0);
  endtask

  task automatic t_level_invalid();
    logic [31:0] d;
    wr(8'h00, 32'd9);
    check("R3 irq at write edge", 32'(irq), 32'd1);
    rd(8'h18, d); check("R3 big error bit1", d, 32'h002);
    repeat (LVL_D + 2) @(negedge clk);
    check("R3 no later complete", 32'(irq), 32'd0);
    rd(8'h00, d); check("R3 big level unchanged", d, 32'd5);
    wr(8'h08, 32'd8);
    rd(8'h18, d); check("R3 little error bit5", d, 32'h020);
    rd(8'h08, d); check("R3 little level unchanged", d, 32'd3);
  endtask

  task automatic t_cfg_read();
    logic [31:0] d;
    wr(8'h10, GO | FN6 | 32'h304 + 32'd2);
    check_window("R4 cfg", CFG_D);
    rd(8'h74, d); check("R5 big entry 2", d, exp_entry(0, 2));
    rd(8'h18, d); check("R4 cfg complete bit8", d, 32'h100);
    wr(8'h10, GO | FN6 | 32'h30C + 32'd7);
    wait_irq();
    rd(8'h74, d); check("R5 little entry 7", d, exp_entry(1, 7));
    rd(8'h18, d); check("R4 cfg complete again", d, 32'h100);
    wr(8'h10, GO | FN6 | 32'h304);
    wait_irq();
    rd(8'h74, d); check("R5 big entry 0", d, exp_entry(0, 0));
    rd(8'h18, d);
  endtask

  task automatic t_cfg_bad();
    logic [31:0] d;
    wr(8'h10, GO | 32'h0050_0000 | 32'h305);
    rd(8'h18, d); check("R6 bad function error bit9", d, 32'h200);
    wr(8'h10, GO | FN6 | 32'h314);
    rd(8'h18, d); check("R6 offset past table", d, 32'h200);
    wr(8'h10, GO | FN6 | 32'h303);
    rd(8'h18, d); check("R6 offset before table", d, 32'h200);
    repeat (CFG_D + 2) @(negedge clk);
    rd(8'h18, d); check("R6 no complete follows", d, 32'h0);
    rd(8'h74, d); check("R6 read data unchanged", d, exp_entry(0, 0));
  endtask

  task automatic t_cfg_nostart();
    logic [31:0] d;
    wr(8'h10, FN6 | 32'h306);
    rd(8'h14, d); check("R7 not busy", d, 32'd0);
    repeat (CFG_D + 3) @(negedge clk);
    check("R7 irq stays low", 32'(irq), 32'd0);
    rd(8'h18, d); check("R7 status empty", d, 32'h0);
    rd(8'h74, d); check("R7 read data unchanged", d, exp_entry(0, 0));
  endtask

  task automatic t_busy_reject();
    logic [31:0] d;
    wr(8'h00, 32'd1);
    wr(8'h08, 32'd2);
    wr(8'h10, GO | FN6 | 32'h307);
    rd(8'h18, d); check("R8 busy errors bits5 and 9", d, 32'h220);
    wait_irq();
    rd(8'h18, d); check("R8 running request completes", d, 32'h001);
    rd(8'h00, d); check("R8 big level", d, 32'd1);
    rd(8'h08, d); check("R8 little level untouched", d, 32'd3);
    rd(8'h74, d); check("R8 read data untouched", d, exp_entry(0, 0));
  endtask

  task automatic t_clear_race();
    logic [31:0] d;
    wr(8'h00, 32'd4);
    repeat (LVL_D - 2) @(negedge clk);
    rd(8'h18, d); check("R9 read on completion edge returns old", d, 32'h0);
    check("R10 irq high after same-edge set", 32'(irq), 32'd1);
    rd(8'h18, d); check("R9 same-edge bit survives", d, 32'h001);
    check("R10 irq low after clear", 32'(irq), 32'd0);
    rd(8'h1C, d); check("R10 flag register", d, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_big_level();
    t_little_level();
    t_level_invalid();
    t_cfg_read();
    t_cfg_bad();
    t_cfg_nostart();
    t_busy_reject();
    t_clear_race();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule